// File: doc/BRIEF.md
# Predicated Branch Resolution Unit

This block decides, once per cycle, where the fetch pointer of a bundle-addressed machine goes next. It receives one decoded branch and the current instruction pointer. The branch is one of three forms: a short relative branch with a 21-bit bundle offset, a long relative branch with a 60-bit bundle offset, or an indirect branch through one of eight 64-bit branch registers. The block returns the next pointer, a taken flag and an illegal flag. Instructions are fetched as 16-byte bundles, so every address the block produces has its low four bits clear.

Whether the branch redirects depends on a qualifying predicate. The unit reads that predicate from an externally held predicate vector. Predicate 0 is hard-wired true, which gives unconditional branches. The unit can also take the predicate from a compare that finishes in the same cycle. That compare result is forwarded combinationally, so a compare and its dependent branch can issue together with no stall. The branch registers live inside the unit and are loaded from a general-register value on the clock edge.

Top module: `brres_unit`

## Requirements
- R1: Short form (`br_form`=0): when taken, `next_ip` equals the aligned sum of `cur_ip` and `br_imm[20:0]` sign-extended and shifted left by four. The reach is from -2^24 bytes up to 2^24-16 bytes.
- R2: Long form (`br_form`=1): when taken, `next_ip` equals the aligned sum of `cur_ip` and all 60 bits of `br_imm` shifted left by four, modulo 2^64.
- R3: Indirect form (`br_form`=2): when taken, `next_ip` is the branch register chosen by `br_breg_sel`, with its low four bits cleared.
- R4: When `br_valid` is low or the qualifying predicate is 0, `taken` is 0. `next_ip` is then `cur_ip` with its low four bits cleared, plus 16.
- R5: Predicate index 0 always reads as 1, even when a same-cycle compare names index 0 as a destination.
- R6: With `cmp_valid` high, a predicate index equal to `cmp_pt` reads `cmp_result`, and an index equal to `cmp_pf` reads its inverse. `cmp_pt` wins when both match. All other indices read `pred_vec`.
- R7: Kind codes are 0 plain, 1 conditional and 2 call. For the long form, kind codes 3 to 15 are illegal. Form code 3 is always illegal. A valid illegal branch raises `illegal`, does not redirect, and advances sequentially.
- R8: When `breg_wr_en` is high, register `breg_wr_sel` takes `breg_wr_data` at the clock edge. An indirect branch reading that register in the same cycle sees the old value.
- R9: Synchronous reset clears all eight branch registers to zero.
- R10: A long branch that falls through advances by exactly one bundle (16 bytes), the same as a short branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A branch is presented this cycle |
| br_form | input | 2 | 0 short relative, 1 long relative, 2 indirect, 3 reserved |
| br_kind | input | 4 | Branch kind code (0 plain, 1 conditional, 2 call) |
| br_imm | input | 60 | Bundle offset; the short form uses bits 20:0 |
| br_breg_sel | input | 3 | Branch register for the indirect form |
| br_qp | input | 6 | Qualifying predicate index |
| cur_ip | input | 64 | Current instruction pointer |
| pred_vec | input | 64 | Committed predicate values, one bit per index |
| cmp_valid | input | 1 | A compare completes this cycle |
| cmp_pt | input | 6 | Predicate index receiving the compare result |
| cmp_pf | input | 6 | Predicate index receiving the inverted result |
| cmp_result | input | 1 | Compare outcome |
| breg_wr_en | input | 1 | Branch register write enable |
| breg_wr_sel | input | 3 | Branch register to write |
| breg_wr_data | input | 64 | General-register value to load |
| next_ip | output | 64 | Next fetch pointer, bundle aligned |
| taken | output | 1 | Branch redirected the pointer |
| illegal | output | 1 | Unsupported form or kind code |

## Verification
The hardest situation to reach is a predicate resolved through the bypass: a compare must name exactly the predicate that the branch qualifies on, in the same cycle, while the committed vector holds the opposite value. The bench sets this up with directed cycles that flip `pred_vec` against `cmp_result` on both the true and the inverted destination. It also biases random stimulus so that compare destinations often equal `br_qp`. A second hard case is a write and an indirect read of the same branch register in one cycle. The bench forces that collision and then checks the following cycle.

// File: rtl/brres_pkg.sv
package brres_pkg;

    localparam int IP_W        = 64;
    localparam int BUNDLE_LSB  = 4;
    localparam int SHORT_IMM_W = 21;
    localparam int LONG_IMM_W  = 60;
    localparam int KIND_W      = 4;

    typedef enum logic [1:0] {
        FORM_SHORT = 2'd0,
        FORM_LONG  = 2'd1,
        FORM_IND   = 2'd2,
        FORM_RSVD  = 2'd3
    } br_form_e;

    localparam logic [KIND_W-1:0] KIND_PLAIN = 4'd0;
    localparam logic [KIND_W-1:0] KIND_COND  = 4'd1;
    localparam logic [KIND_W-1:0] KIND_CALL  = 4'd2;

    typedef struct packed {
        logic [IP_W-1:0] nip;
        logic            taken;
        logic            illegal;
    } br_res_t;

    function automatic logic [IP_W-1:0] bundle_align(input logic [IP_W-1:0] a);
        return {a[IP_W-1:BUNDLE_LSB], {BUNDLE_LSB{1'b0}}};
    endfunction

    function automatic logic [IP_W-1:0] seq_next(input logic [IP_W-1:0] ip);
        return bundle_align(ip) + IP_W'(1 << BUNDLE_LSB);
    endfunction

    function automatic logic long_kind_ok(input logic [KIND_W-1:0] k);
        return (k == KIND_PLAIN) || (k == KIND_COND) || (k == KIND_CALL);
    endfunction

endpackage

// File: rtl/brres_predsel.sv
module brres_predsel #(
    parameter int NUM_PRED = 64,
    localparam int PIDX_W  = $clog2(NUM_PRED)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PRED-1:0] pred_vec,
    input  logic [PIDX_W-1:0]   qp_idx,
    input  logic                cmp_valid,
    input  logic [PIDX_W-1:0]   cmp_pt,
    input  logic [PIDX_W-1:0]   cmp_pf,
    input  logic                cmp_result,
    output logic                qp_val
);

    always_comb begin
        qp_val = pred_vec[qp_idx];
        if (cmp_valid && (cmp_pf == qp_idx)) qp_val = ~cmp_result;
        if (cmp_valid && (cmp_pt == qp_idx)) qp_val = cmp_result;
        if (qp_idx == '0) qp_val = 1'b1;
    end

    // R5: index 0 reads true whatever the compare writes
    a_r5_p0_true: assert property (@(posedge clk) disable iff (rst)
        (qp_idx == '0) |-> qp_val);

    // R6: forwarded compare result reaches the branch in the same cycle
    a_r6_bypass_pt: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_pt == qp_idx && qp_idx != '0) |-> (qp_val == cmp_result));

    a_r6_bypass_pf: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_pf == qp_idx && cmp_pt != qp_idx && qp_idx != '0)
        |-> (qp_val == !cmp_result));

endmodule

// File: rtl/brres_bregs.sv
module brres_bregs #(
    parameter int NUM_BREG = 8,
    parameter int W        = 64,
    localparam int SEL_W   = $clog2(NUM_BREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [W-1:0]     rd_data
);

    logic [W-1:0] regs [NUM_BREG];

    for (genvar g = 0; g < NUM_BREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g)))
                regs[g] <= wr_data;
        end
    end

    assign rd_data = regs[rd_sel];

    // R8: a write lands in the selected register one edge later
    a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (regs[$past(wr_sel)] == $past(wr_data)));

    // R9: the cycle after reset every read returns zero
    a_r9_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == '0));

endmodule

// File: rtl/brres_target.sv
module brres_target
    import brres_pkg::*;
#(
    parameter int SHORT_W = SHORT_IMM_W,
    parameter int LONG_W  = LONG_IMM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  br_form_e          form,
    input  logic [LONG_W-1:0] imm,
    input  logic [IP_W-1:0]   cur_ip,
    input  logic [IP_W-1:0]   breg_val,
    output logic [IP_W-1:0]   target
);

    logic [IP_W-1:0] off_short, off_long, rel_short, rel_long;
    logic [IP_W-1:0] span;

    assign off_short = {{(IP_W-SHORT_W){imm[SHORT_W-1]}}, imm[SHORT_W-1:0]} << BUNDLE_LSB;
    assign off_long  = {{(IP_W-LONG_W){imm[LONG_W-1]}}, imm} << BUNDLE_LSB;
    assign rel_short = bundle_align(cur_ip + off_short);
    assign rel_long  = bundle_align(cur_ip + off_long);

    always_comb begin
        unique case (form)
            FORM_SHORT: target = rel_short;
            FORM_LONG:  target = rel_long;
            FORM_IND:   target = bundle_align(breg_val);
            default:    target = seq_next(cur_ip);
        endcase
    end

    // R1: a short target stays within 2^24 bytes of the aligned pointer
    assign span = target - bundle_align(cur_ip);
    a_r1_short_reach: assert property (@(posedge clk) disable iff (rst)
        (form == FORM_SHORT) |-> ((&span[IP_W-1:24]) || !(|span[IP_W-1:24])));

endmodule

// File: rtl/brres_unit.sv
module brres_unit
    import brres_pkg::*;
#(
    parameter int NUM_BREG = 8,
    parameter int NUM_PRED = 64,
    localparam int BSEL_W  = $clog2(NUM_BREG),
    localparam int PIDX_W  = $clog2(NUM_PRED)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  br_valid,
    input  logic [1:0]            br_form,
    input  logic [KIND_W-1:0]     br_kind,
    input  logic [LONG_IMM_W-1:0] br_imm,
    input  logic [BSEL_W-1:0]     br_breg_sel,
    input  logic [PIDX_W-1:0]     br_qp,
    input  logic [IP_W-1:0]       cur_ip,
    input  logic [NUM_PRED-1:0]   pred_vec,
    input  logic                  cmp_valid,
    input  logic [PIDX_W-1:0]     cmp_pt,
    input  logic [PIDX_W-1:0]     cmp_pf,
    input  logic                  cmp_result,
    input  logic                  breg_wr_en,
    input  logic [BSEL_W-1:0]     breg_wr_sel,
    input  logic [IP_W-1:0]       breg_wr_data,
    output logic [IP_W-1:0]       next_ip,
    output logic                  taken,
    output logic                  illegal
);

    br_form_e        form;
    logic            qp_val;
    logic [IP_W-1:0] breg_val;
    logic [IP_W-1:0] target;
    logic            accept;
    br_res_t         res;

    assign form = br_form_e'(br_form);

    brres_predsel #(.NUM_PRED(NUM_PRED)) u_pred (
        .clk(clk), .rst(rst),
        .pred_vec(pred_vec), .qp_idx(br_qp),
        .cmp_valid(cmp_valid), .cmp_pt(cmp_pt), .cmp_pf(cmp_pf),
        .cmp_result(cmp_result), .qp_val(qp_val)
    );

    brres_bregs #(.NUM_BREG(NUM_BREG), .W(IP_W)) u_bregs (
        .clk(clk), .rst(rst),
        .wr_en(breg_wr_en), .wr_sel(breg_wr_sel), .wr_data(breg_wr_data),
        .rd_sel(br_breg_sel), .rd_data(breg_val)
    );

    brres_target u_tgt (
        .clk(clk), .rst(rst),
        .form(form), .imm(br_imm), .cur_ip(cur_ip),
        .breg_val(breg_val), .target(target)
    );

    always_comb begin
        accept = 1'b1;
        if (form == FORM_RSVD) accept = 1'b0;
        if (form == FORM_LONG && !long_kind_ok(br_kind)) accept = 1'b0;

        res.illegal = br_valid && !accept;
        res.taken   = br_valid && accept && qp_val;
        res.nip     = res.taken ? target : seq_next(cur_ip);
    end

    assign next_ip = res.nip;
    assign taken   = res.taken;
    assign illegal = res.illegal;

    // R7: an illegal branch never redirects
    a_r7_illegal_no_take: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !taken);

    // R4 / R10: any non-redirect advances exactly one bundle
    a_r4_seq_advance: assert property (@(posedge clk) disable iff (rst)
        !taken |-> (next_ip == seq_next(cur_ip)));

    // R4: nothing is taken without a presented branch
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !br_valid |-> (!taken && !illegal));

endmodule

// File: tb/brres_unit_tb.sv
module brres_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_valid = 1'b0;
    logic [1:0]  br_form = '0;
    logic [3:0]  br_kind = '0;
    logic [59:0] br_imm = '0;
    logic [2:0]  br_breg_sel = '0;
    logic [5:0]  br_qp = '0;
    logic [63:0] cur_ip = '0;
    logic [63:0] pred_vec = '0;
    logic        cmp_valid = 1'b0;
    logic [5:0]  cmp_pt = '0;
    logic [5:0]  cmp_pf = '0;
    logic        cmp_result = 1'b0;
    logic        breg_wr_en = 1'b0;
    logic [2:0]  breg_wr_sel = '0;
    logic [63:0] breg_wr_data = '0;
    logic [63:0] next_ip;
    logic        taken;
    logic        illegal;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] m_breg [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    brres_unit dut_i (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_form(br_form),
        .br_kind(br_kind), .br_imm(br_imm), .br_breg_sel(br_breg_sel),
        .br_qp(br_qp), .cur_ip(cur_ip), .pred_vec(pred_vec),
        .cmp_valid(cmp_valid), .cmp_pt(cmp_pt), .cmp_pf(cmp_pf),
        .cmp_result(cmp_result), .breg_wr_en(breg_wr_en),
        .breg_wr_sel(breg_wr_sel), .breg_wr_data(breg_wr_data),
        .next_ip(next_ip), .taken(taken), .illegal(illegal)
    );

    function automatic logic [63:0] al(input logic [63:0] a);
        return a & ~64'hF;
    endfunction

    function automatic void model(output logic [63:0] nip, output logic tk,
                                  output logic il);
        logic q, ok;
        logic [63:0] tgt, seq;
        seq = al(cur_ip) + 64'd16;
        if (br_qp == 0) q = 1'b1;
        else if (cmp_valid && cmp_pt == br_qp) q = cmp_result;
        else if (cmp_valid && cmp_pf == br_qp) q = !cmp_result;
        else q = pred_vec[br_qp];
        ok = !(br_form == 2'd3) && !(br_form == 2'd1 && br_kind > 4'd2);
        case (br_form)
            2'd0: tgt = al(cur_ip + ({{43{br_imm[20]}}, br_imm[20:0]} * 64'd16));
            2'd1: tgt = al(cur_ip + ({{4{br_imm[59]}}, br_imm} * 64'd16));
            default: tgt = al(m_breg[br_breg_sel]);
        endcase
        il  = br_valid && !ok;
        tk  = br_valid && ok && q;
        nip = tk ? tgt : seq;
    endfunction

    task automatic report(string req, logic [63:0] a_ip, logic a_tk, logic a_il,
                          logic [63:0] e_ip, logic e_tk, logic e_il);
        n_tests++;
        if (a_ip !== e_ip || a_tk !== e_tk || a_il !== e_il) begin
            n_fail++;
            $display("FAIL %s: got ip=%h tk=%b il=%b expected ip=%h tk=%b il=%b",
                     req, a_ip, a_tk, a_il, e_ip, e_tk, e_il);
        end
    endtask

    // Inputs are already set after a negedge; check, then commit one edge.
    task automatic step(string req);
        logic [63:0] e_ip; logic e_tk, e_il;
        #1;
        model(e_ip, e_tk, e_il);
        report(req, next_ip, taken, illegal, e_ip, e_tk, e_il);
        @(posedge clk);
        if (breg_wr_en) m_breg[breg_wr_sel] = breg_wr_data;
        @(negedge clk);
    endtask

    task automatic step_lit(string req, logic [63:0] e_ip, logic e_tk, logic e_il);
        #1;
        report(req, next_ip, taken, illegal, e_ip, e_tk, e_il);
        @(posedge clk);
        if (breg_wr_en) m_breg[breg_wr_sel] = breg_wr_data;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        br_valid = 0; br_form = 0; br_kind = 0; br_imm = 0; br_breg_sel = 0;
        br_qp = 0; cur_ip = 0; pred_vec = 0; cmp_valid = 0; cmp_pt = 0;
        cmp_pf = 0; cmp_result = 0; breg_wr_en = 0; breg_wr_sel = 0;
        breg_wr_data = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_b7a1));
        for (int i = 0; i < 8; i++) m_breg[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R9 R3: after reset an unconditional indirect branch goes to 0
        br_valid = 1; br_form = 2; br_breg_sel = 5; cur_ip = 64'h4000;
        step_lit("R9", 64'h0, 1'b1, 1'b0);

        // R4: idle cycle does nothing
        idle_inputs(); cur_ip = 64'h1230;
        step_lit("R4", 64'h1240, 1'b0, 1'b0);

        // R1: largest forward short offset
        idle_inputs(); br_valid = 1; br_form = 0; br_imm = 60'h0FFFFF; cur_ip = 64'h1000;
        step_lit("R1", 64'h1000 + 64'hFFFFF0, 1'b1, 1'b0);
        // R1: most negative short offset, upper immediate bits ignored
        br_imm = {39'h7F_FFFF_FFFF, 21'h100000}; cur_ip = 64'h2000_0000;
        step_lit("R1", 64'h1F00_0000, 1'b1, 1'b0);

        // R2: long offset of -1 bundle
        br_form = 1; br_kind = 2; br_imm = '1; cur_ip = 64'h100;
        step_lit("R2", 64'hF0, 1'b1, 1'b0);
        // R2: long offset wraps around the address space
        br_kind = 1; br_imm = 60'h800_0000_0000_0000; cur_ip = 64'h10;
        step_lit("R2", 64'h8000_0000_0000_0010, 1'b1, 1'b0);

        // R7: long form with kind 5 and reserved form code
        br_kind = 5; cur_ip = 64'h700;
        step_lit("R7", 64'h710, 1'b0, 1'b1);
        br_form = 3; br_kind = 0;
        step_lit("R7", 64'h710, 1'b0, 1'b1);
        // R7: short form accepts kind 5
        br_form = 0; br_kind = 5; br_imm = 60'h1; cur_ip = 64'h700;
        step_lit("R7", 64'h710, 1'b1, 1'b0);

        // R4 R10: predicate false, long form falls through by one bundle
        br_form = 1; br_kind = 1; br_qp = 9; pred_vec = 0; br_imm = 60'h44;
        cur_ip = 64'hABC7;
        step_lit("R10", 64'hABD0, 1'b0, 1'b0);

        // R6: bypass true destination overrides committed 0
        br_form = 0; br_imm = 60'h3; br_qp = 7; pred_vec = 0; cur_ip = 64'h500;
        cmp_valid = 1; cmp_pt = 7; cmp_pf = 8; cmp_result = 1;
        step_lit("R6", 64'h530, 1'b1, 1'b0);
        // R6: false destination sees the inverse, overriding committed 1
        pred_vec = 64'h80; cmp_pt = 8; cmp_pf = 7; cmp_result = 1;
        step_lit("R6", 64'h510, 1'b0, 1'b0);
        // R6: pt wins when both name the same index
        cmp_pt = 7; cmp_pf = 7; cmp_result = 0;
        step_lit("R6", 64'h510, 1'b0, 1'b0);

        // R5: compare naming index 0 with result 0 does not clear it
        br_qp = 0; cmp_pt = 0; cmp_pf = 0; cmp_result = 0;
        step_lit("R5", 64'h530, 1'b1, 1'b0);

        // R8: same-cycle write and read of register 3 sees the old value
        idle_inputs(); br_valid = 1; br_form = 2; br_breg_sel = 3; cur_ip = 64'h900;
        breg_wr_en = 1; breg_wr_sel = 3; breg_wr_data = 64'hDEAD_BEEF_CAFE_1237;
        step_lit("R8", 64'h0, 1'b1, 1'b0);
        breg_wr_en = 0;
        step_lit("R8", 64'hDEAD_BEEF_CAFE_1230, 1'b1, 1'b0);

        // Random mix over R1-style forms, checked by the bench model
        for (int i = 0; i < 600; i++) begin
            br_valid     = ($urandom_range(0, 9) != 0);
            br_form      = 2'($urandom_range(0, 3));
            br_kind      = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'($urandom_range(0, 2));
            br_imm       = {28'($urandom), 32'($urandom)};
            br_breg_sel  = 3'($urandom);
            br_qp        = ($urandom_range(0, 4) == 0) ? 6'd0 : 6'($urandom);
            cur_ip       = {32'($urandom), 32'($urandom)};
            pred_vec     = {32'($urandom), 32'($urandom)};
            cmp_valid    = 1'($urandom);
            cmp_pt       = ($urandom_range(0, 2) == 0) ? br_qp : 6'($urandom);
            cmp_pf       = ($urandom_range(0, 2) == 0) ? br_qp : 6'($urandom);
            cmp_result   = 1'($urandom);
            breg_wr_en   = 1'($urandom);
            breg_wr_sel  = ($urandom_range(0, 1) == 0) ? br_breg_sel : 3'($urandom);
            breg_wr_data = {32'($urandom), 32'($urandom)};
            case (br_form)
                2'd0: step("R1");
                2'd1: step("R2");
                2'd2: step("R3");
                default: step("R7");
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule